// File: doc/BRIEF.md
# Tone Guard-Time Steering Qualifier

This block sits behind a tone detector that delivers, on every clock, a raw "tone seen" flag and a 4-bit digit code. It turns that noisy stream into two views. An early flag simply follows the raw flag one clock later, so that downstream logic can react quickly. A qualified digit flag rises only once a tone has stayed present with an unchanged code for a programmable number of millisecond ticks. It falls only after silence has lasted a second programmable number of ticks. At the qualified rise the block latches the code, and a readout stage can then fetch that held code.

Because the rise and the fall use separate guard times, a short dropout inside one tone does not split it into two digits, and a burst shorter than the presence time never produces a digit. A change of code while the tone is present restarts the presence count, so a tone that another tone disturbs is not accepted. The timebase is a tick made by dividing the system clock by `DIV`. At 4.194304 MHz and `DIV` = 4096 one tick is 0.9765625 ms. A guard time of N ticks is satisfied on the N-th tick seen under the right condition, so the real wait lies between N-1 and N tick periods.

Top module: `tone_guard_qual`

## Requirements
- R1: After reset `early_o`, `valid_o` and `code_o` are 0, and both guard times are 20 ticks.
- R2: `early_o` equals `tone_det_i` delayed by exactly one clock.
- R3: The tick pulses once every `DIV` clocks, and the first pulse comes `DIV` clocks after reset. While `valid_o` is low, each tick seen with the tone present and the code unchanged from the previous clock adds one to a presence count. `valid_o` rises on the clock after the tick that brings the count to the presence time. A presence time of 0 acts as 1.
- R4: A tone that drops before the presence count completes leaves `valid_o` low. The count restarts from zero on the next tone.
- R5: `code_o` takes the value of `code_i` at the clock where `valid_o` rises. It holds that value at all other times, including while `valid_o` is low.
- R6: While `valid_o` is high, each tick seen with the tone absent adds one to an absence count, and any clock with the tone present clears it. `valid_o` falls on the clock after the tick that brings the count to the absence time. A gap shorter than that keeps one digit, with no new rise and no new code capture.
- R7: Any clock where `code_i` differs from its value on the previous clock, while `valid_o` is low, clears the presence count.
- R8: When `cfg_we_i` is high at a clock edge, `cfg_pres_i` and `cfg_abs_i` become the presence and absence times, counted in ticks, from the next clock on.
- R9: `valid_o` rises only on the clock after a tick with the tone present. It falls only on the clock after a tick with the tone absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tone_det_i | input | 1 | Raw tone-present flag from the detector |
| code_i | input | 4 | Digit code from the detector |
| cfg_we_i | input | 1 | Load strobe for both guard times |
| cfg_pres_i | input | 8 | New presence time in ticks |
| cfg_abs_i | input | 8 | New absence time in ticks |
| early_o | output | 1 | Fast tone indication |
| valid_o | output | 1 | Qualified digit present |
| code_o | output | 4 | Code latched at the qualified rise |

## Verification
The hardest case to reach is a tone that lasts longer than the presence time in total but is never accepted, because its code changes partway through. The stimulus holds one code for 15 ticks and then switches to another code for 15 ticks, with the tone present throughout. It then extends the second code until that code qualifies on its own. A gap of a few ticks inside an accepted digit is driven with a different code during the gap, to show that the held code survives. A behavioural reference model runs in the bench and is compared with all three outputs on every clock. Fixed checks at each scenario boundary back it up.

// File: rtl/tone_qual_pkg.sv
package tone_qual_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned MS_W     = 8;
  localparam int unsigned DEF_PRES = 20;
  localparam int unsigned DEF_ABS  = 20;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_HOLD = 1'b1
  } qual_state_e;
endpackage

// File: rtl/tone_ms_tick.sv
module tone_ms_tick #(
  parameter int unsigned DIV = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/tone_cfg_regs.sv
module tone_cfg_regs
  import tone_qual_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [MS_W-1:0] pres_i,
  input  logic [MS_W-1:0] abs_i,
  output logic [MS_W-1:0] pres_o,
  output logic [MS_W-1:0] abs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_o <= MS_W'(DEF_PRES);
      abs_o  <= MS_W'(DEF_ABS);
    end else if (we_i) begin
      pres_o <= pres_i;
      abs_o  <= abs_i;
    end
  end
endmodule

// File: rtl/tone_guard_fsm.sv
module tone_guard_fsm
  import tone_qual_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tone_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MS_W-1:0]   pres_i,
  input  logic [MS_W-1:0]   abs_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  qual_state_e       state_q;
  logic [MS_W-1:0]   cnt_q;
  logic [MS_W:0]     cnt_nx;
  logic [CODE_W-1:0] prev_q;
  logic              code_chg;

  assign cnt_nx   = {1'b0, cnt_q} + {{MS_W{1'b0}}, 1'b1};
  assign code_chg = (code_i != prev_q);
  assign valid_o  = (state_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      prev_q  <= '0;
      code_o  <= '0;
    end else begin
      prev_q <= code_i;
      unique case (state_q)
        ST_WAIT: begin
          if (!tone_i || code_chg) begin
            cnt_q <= '0;
          end else if (tick_i) begin
            if (cnt_nx >= {1'b0, pres_i}) begin
              state_q <= ST_HOLD;
              cnt_q   <= '0;
              code_o  <= code_i;
            end else begin
              cnt_q <= cnt_nx[MS_W-1:0];
            end
          end
        end
        ST_HOLD: begin
          if (tone_i) begin
            cnt_q <= '0;
          end else if (tick_i) begin
            if (cnt_nx >= {1'b0, abs_i}) begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_nx[MS_W-1:0];
            end
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/tone_guard_qual.sv
module tone_guard_qual
  import tone_qual_pkg::*;
#(
  parameter int unsigned DIV = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tone_det_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              cfg_we_i,
  input  logic [MS_W-1:0]   cfg_pres_i,
  input  logic [MS_W-1:0]   cfg_abs_i,
  output logic              early_o,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic            tick;
  logic [MS_W-1:0] pres_ms;
  logic [MS_W-1:0] abs_ms;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) early_o <= 1'b0;
    else         early_o <= tone_det_i;
  end

  tone_ms_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tone_cfg_regs u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .pres_i (cfg_pres_i),
    .abs_i  (cfg_abs_i),
    .pres_o (pres_ms),
    .abs_o  (abs_ms)
  );

  tone_guard_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .tone_i  (tone_det_i),
    .code_i  (code_i),
    .pres_i  (pres_ms),
    .abs_i   (abs_ms),
    .valid_o (valid_o),
    .code_o  (code_o)
  );
endmodule

// File: rtl/tone_guard_qual_chk.sv
module tone_guard_qual_chk
  import tone_qual_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tone_det_i,
  input logic              tick_i,
  input logic              early_o,
  input logic              valid_o,
  input logic [CODE_W-1:0] code_o
);
  assert_early_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o == $past(tone_det_i));

  assert_code_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> $rose(valid_o));

  assert_rise_on_tone_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(tone_det_i) && $past(tick_i)));

  assert_fall_on_quiet_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> (!$past(tone_det_i) && $past(tick_i)));

  assert_rise_needs_early_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> early_o);
endmodule

bind tone_guard_qual tone_guard_qual_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tone_det_i (tone_det_i),
  .tick_i     (tick),
  .early_o    (early_o),
  .valid_o    (valid_o),
  .code_o     (code_o)
);

// File: tb/sim_tone_guard_qual.sv
`timescale 1ns/1ps
module sim_tone_guard_qual;
  localparam int DIV = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tone_det_i = 1'b0;
  logic [3:0] code_i = 4'd0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_pres_i = 8'd0;
  logic [7:0] cfg_abs_i = 8'd0;
  logic       early_o, valid_o;
  logic [3:0] code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tone_guard_qual #(.DIV(DIV)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tone_det_i(tone_det_i), .code_i(code_i),
    .cfg_we_i(cfg_we_i), .cfg_pres_i(cfg_pres_i), .cfg_abs_i(cfg_abs_i),
    .early_o(early_o), .valid_o(valid_o), .code_o(code_o)
  );

  // behavioural reference
  int m_div, m_cnt, m_pres, m_abs, m_code, m_prev;
  bit m_early, m_valid, m_tick;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_cnt = 0; m_pres = 20; m_abs = 20;
      m_code = 0; m_prev = 0; m_early = 0; m_valid = 0;
    end else begin
      m_tick = (m_div == DIV - 1);
      m_div  = m_tick ? 0 : m_div + 1;
      m_early = tone_det_i;
      if (!m_valid) begin
        if (!tone_det_i || int'(code_i) != m_prev) m_cnt = 0;
        else if (m_tick) begin
          m_cnt++;
          if (m_cnt >= m_pres) begin m_valid = 1; m_cnt = 0; m_code = int'(code_i); end
        end
      end else begin
        if (tone_det_i) m_cnt = 0;
        else if (m_tick) begin
          m_cnt++;
          if (m_cnt >= m_abs) begin m_valid = 0; m_cnt = 0; end
        end
      end
      m_prev = int'(code_i);
      if (cfg_we_i) begin m_pres = int'(cfg_pres_i); m_abs = int'(cfg_abs_i); end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R2 early", int'(early_o), int'(m_early));
      check("R3 valid", int'(valid_o), int'(m_valid));
      check("R5 code",  int'(code_o),  m_code);
    end
  end

  task automatic drive(bit t, int c, int ticks);
    tone_det_i = t;
    code_i = 4'(c);
    repeat (ticks * DIV) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 valid at reset", int'(valid_o), 0);
    check("R1 early at reset", int'(early_o), 0);
    check("R1 code at reset",  int'(code_o), 0);
    rst_ni = 1'b1;
    // R4: short burst rejected
    drive(1, 5, 10);
    drive(0, 5, 3);
    check("R4 burst rejected", int'(valid_o), 0);
    // R3/R5: long tone qualifies with default 20
    drive(1, 5, 18);
    check("R1 default presence not yet met", int'(valid_o), 0);
    drive(1, 5, 5);
    check("R3 tone accepted", int'(valid_o), 1);
    check("R5 code latched", int'(code_o), 5);
    // R6: short gap joins, code changed during gap has no effect
    drive(0, 9, 5);
    drive(1, 5, 5);
    check("R6 gap joined", int'(valid_o), 1);
    check("R5 code held through gap", int'(code_o), 5);
    // R6: long gap ends digit
    drive(0, 0, 25);
    check("R6 digit released", int'(valid_o), 0);
    check("R5 code held while idle", int'(code_o), 5);
    // R7: code change restarts presence count
    drive(1, 3, 15);
    drive(1, 9, 15);
    check("R7 changed code not accepted", int'(valid_o), 0);
    drive(1, 9, 7);
    check("R7 new code accepted", int'(valid_o), 1);
    check("R7 code is new", int'(code_o), 9);
    drive(0, 0, 25);
    // R8: reprogram guard times
    cfg_pres_i = 8'd3; cfg_abs_i = 8'd2; cfg_we_i = 1'b1;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
    drive(1, 12, 5);
    check("R8 short presence time", int'(valid_o), 1);
    check("R8 code", int'(code_o), 12);
    drive(0, 12, 3);
    check("R8 short absence time", int'(valid_o), 0);
    // R3: zero presence time acts as one
    cfg_pres_i = 8'd0; cfg_we_i = 1'b1;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
    drive(1, 7, 2);
    check("R3 zero presence", int'(valid_o), 1);
    check("R3 zero presence code", int'(code_o), 7);
    drive(0, 7, 4);
    finish_run();
  end
endmodule